// File: doc/BRIEF.md
# Capability Load Tag Filter

This block performs the last step of a capability load, once the memory read has returned. It takes four inputs: the page-policy verdict that address translation produced for the access, the loaded capability and its tag, the load-capability permission of the authorizing capability, and any exception the memory read reported. From these it decides three things: what reaches the destination register, whether the instruction retires, and which exception, if any, is raised. For load-reserved forms it also decides whether the address reservation is set.

The page-policy verdict has three meaningful values. A pass verdict lets the tag survive only if the authority permits capability loads. A strip verdict always clears the tag. A trap verdict faults only when the loaded value actually carries a tag. An untagged value therefore flows through unchanged even from a trapping page. A fault reported by the memory read overrides the verdict.

All results are registered. They appear together with a one-cycle output-valid pulse on the cycle after the input strobe.

Top module: `cap_load_filter`

## Requirements
- R1: While reset is asserted and after its release, with no strobe issued, out_valid, rd_we, retire_ok, retire_fail and resv_set are 0 and exc_code is 0.
- R2: Every cycle with in_valid high produces exactly one out_valid pulse on the following cycle, and out_valid is never high otherwise.
- R3: With verdict 0 (pass) and no memory fault, rd_cap equals the loaded value, rd_tag equals ld_tag AND auth_lc_perm, rd_we is 1 and retire_ok is 1.
- R4: With verdict 1 (strip) and no memory fault, rd_cap equals the loaded value, rd_tag is 0, rd_we is 1 and retire_ok is 1.
- R5: With verdict 2 (trap), ld_tag set and no memory fault, rd_we is 0 and retire_fail is 1. exc_code is 2 (capability-load page fault) and exc_vaddr equals vaddr. rd_cap and rd_tag keep the last written value.
- R6: With verdict 2, ld_tag clear and no memory fault, the loaded value is written unchanged with rd_tag 0, rd_we is 1 and retire_ok is 1.
- R7: With mem_fault set, whatever the verdict: rd_we is 0 and retire_fail is 1. exc_code is 1, exc_mem_cause equals mem_cause and exc_vaddr equals vaddr.
- R8: resv_set is 1 exactly when lr_variant was set and the load retired successfully (pass, strip, or trap with tag clear). It is 0 when a fault is raised or lr_variant is clear.
- R9: Verdict code 3 is treated exactly like verdict 2.
- R10: With out_valid high, exactly one of retire_ok and retire_fail is high, and exc_code is nonzero exactly when retire_fail is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| in_valid | input | 1 | One-cycle strobe: a returned load is presented |
| verdict | input | 2 | Page-policy verdict: 0 pass, 1 strip, 2 trap, 3 treated as trap |
| ld_cap | input | CAP_W | Loaded capability value bits |
| ld_tag | input | 1 | Loaded capability tag |
| auth_lc_perm | input | 1 | Load-capability permission of the authorizing capability |
| mem_fault | input | 1 | The memory read reported an exception |
| mem_cause | input | CAUSE_W | Cause of the memory-read exception |
| lr_variant | input | 1 | Access is a load-reserved form |
| vaddr | input | ADDR_W | Virtual address of the access |
| out_valid | output | 1 | Results valid pulse, one cycle after in_valid |
| rd_cap | output | CAP_W | Value for the destination register |
| rd_tag | output | 1 | Tag for the destination register |
| rd_we | output | 1 | Destination register write enable |
| retire_ok | output | 1 | Instruction retires successfully |
| retire_fail | output | 1 | Instruction retires with an exception |
| exc_code | output | 2 | 0 none, 1 memory fault passthrough, 2 capability-load page fault |
| exc_mem_cause | output | CAUSE_W | Forwarded memory fault cause |
| exc_vaddr | output | ADDR_W | Faulting virtual address |
| resv_set | output | 1 | Set the load reservation |

## Verification
Every result of a strobe is due on the single cycle after that strobe's rising edge, and no result is due earlier or later. Each expectation the driver queues records the clock count at which it is due. The monitor samples on falling edges only. It flags a pulse that arrives with no expectation pending, or at a count other than the one recorded. It also flags a due expectation whose pulse is missing. For loads that do not write, the expected destination value is the last value the bench model wrote, so the hold behaviour is checked at the ports.

// File: rtl/cap_ld_pkg.sv
package cap_ld_pkg;

  typedef enum logic [1:0] {
    LDV_PASS  = 2'd0,
    LDV_STRIP = 2'd1,
    LDV_TRAP  = 2'd2,
    LDV_RSVD  = 2'd3
  } ldv_e;

  typedef enum logic [1:0] {
    XC_NONE   = 2'd0,
    XC_MEMFLT = 2'd1,
    XC_CAPPF  = 2'd2
  } xc_e;

  localparam int unsigned XC_W = 2;

endpackage

// File: rtl/cap_ld_decide.sv
module cap_ld_decide
  import cap_ld_pkg::*;
(
  input  logic [1:0]      verdict,
  input  logic            ld_tag,
  input  logic            auth_lc,
  input  logic            mem_fault,
  input  logic            lr,
  output logic            wr_en,
  output logic            nxt_tag,
  output logic            ok,
  output logic [XC_W-1:0] xc,
  output logic            resv
);

  logic trap_hit;

  always_comb begin
    trap_hit = 1'b0;
    nxt_tag  = 1'b0;
    unique case (ldv_e'(verdict))
      LDV_PASS:  nxt_tag = ld_tag & auth_lc;
      LDV_STRIP: nxt_tag = 1'b0;
      default: begin
        // trap and reserved code: fault only on a tagged value
        trap_hit = ld_tag;
        nxt_tag  = ld_tag;
      end
    endcase

    wr_en = 1'b1;
    ok    = 1'b1;
    xc    = XC_NONE;
    resv  = lr;
    if (mem_fault) begin
      wr_en = 1'b0;
      ok    = 1'b0;
      xc    = XC_MEMFLT;
      resv  = 1'b0;
    end else if (trap_hit) begin
      wr_en = 1'b0;
      ok    = 1'b0;
      xc    = XC_CAPPF;
      resv  = 1'b0;
    end
  end

endmodule

// File: rtl/cap_ld_outreg.sv
module cap_ld_outreg
  import cap_ld_pkg::*;
#(
  parameter int unsigned CAP_W   = 64,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               d_wr,
  input  logic               d_tag,
  input  logic [CAP_W-1:0]   d_cap,
  input  logic               d_ok,
  input  logic [XC_W-1:0]    d_xc,
  input  logic               d_resv,
  input  logic [ADDR_W-1:0]  d_vaddr,
  input  logic [CAUSE_W-1:0] d_mcause,
  output logic               q_valid,
  output logic               q_we,
  output logic               q_ok,
  output logic               q_fail,
  output logic [XC_W-1:0]    q_xc,
  output logic               q_resv,
  output logic [CAP_W-1:0]   q_cap,
  output logic               q_tag,
  output logic [ADDR_W-1:0]  q_vaddr,
  output logic [CAUSE_W-1:0] q_mcause
);

  logic               vld_d, we_d, ok_d, fail_d, resv_d;
  logic [XC_W-1:0]    xc_d;
  logic               cap_en, flt_en;

  always_comb begin
    vld_d  = in_valid;
    we_d   = in_valid & d_wr;
    ok_d   = in_valid & d_ok;
    fail_d = in_valid & ~d_ok;
    resv_d = in_valid & d_resv;
    xc_d   = in_valid ? d_xc : XC_NONE;
    cap_en = in_valid & d_wr;
    flt_en = in_valid & ~d_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_we    <= 1'b0;
      q_ok    <= 1'b0;
      q_fail  <= 1'b0;
      q_resv  <= 1'b0;
      q_xc    <= XC_NONE;
    end else begin
      q_valid <= vld_d;
      q_we    <= we_d;
      q_ok    <= ok_d;
      q_fail  <= fail_d;
      q_resv  <= resv_d;
      q_xc    <= xc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cap <= '0;
      q_tag <= 1'b0;
    end else if (cap_en) begin
      q_cap <= d_cap;
      q_tag <= d_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vaddr  <= '0;
      q_mcause <= '0;
    end else if (flt_en) begin
      q_vaddr  <= d_vaddr;
      q_mcause <= d_mcause;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> q_valid);
  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !q_valid);
  assert_one_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> $countones({q_ok, q_fail}) == 1);
  assert_code_iff_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ((q_xc != XC_NONE) == q_fail));
  assert_hold_on_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !q_we |-> $stable(q_cap) && $stable(q_tag));
  assert_resv_needs_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_resv |-> q_ok);

endmodule

// File: rtl/cap_load_filter.sv
module cap_load_filter
  import cap_ld_pkg::*;
#(
  parameter int unsigned CAP_W   = 64,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         verdict,
  input  logic [CAP_W-1:0]   ld_cap,
  input  logic               ld_tag,
  input  logic               auth_lc_perm,
  input  logic               mem_fault,
  input  logic [CAUSE_W-1:0] mem_cause,
  input  logic               lr_variant,
  input  logic [ADDR_W-1:0]  vaddr,
  output logic               out_valid,
  output logic [CAP_W-1:0]   rd_cap,
  output logic               rd_tag,
  output logic               rd_we,
  output logic               retire_ok,
  output logic               retire_fail,
  output logic [1:0]         exc_code,
  output logic [CAUSE_W-1:0] exc_mem_cause,
  output logic [ADDR_W-1:0]  exc_vaddr,
  output logic               resv_set
);

  logic            dec_wr, dec_tag, dec_ok, dec_resv;
  logic [XC_W-1:0] dec_xc;

  cap_ld_decide u_decide (
    .verdict   (verdict),
    .ld_tag    (ld_tag),
    .auth_lc   (auth_lc_perm),
    .mem_fault (mem_fault),
    .lr        (lr_variant),
    .wr_en     (dec_wr),
    .nxt_tag   (dec_tag),
    .ok        (dec_ok),
    .xc        (dec_xc),
    .resv      (dec_resv)
  );

  cap_ld_outreg #(
    .CAP_W   (CAP_W),
    .ADDR_W  (ADDR_W),
    .CAUSE_W (CAUSE_W)
  ) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d_wr     (dec_wr),
    .d_tag    (dec_tag),
    .d_cap    (ld_cap),
    .d_ok     (dec_ok),
    .d_xc     (dec_xc),
    .d_resv   (dec_resv),
    .d_vaddr  (vaddr),
    .d_mcause (mem_cause),
    .q_valid  (out_valid),
    .q_we     (rd_we),
    .q_ok     (retire_ok),
    .q_fail   (retire_fail),
    .q_xc     (exc_code),
    .q_resv   (resv_set),
    .q_cap    (rd_cap),
    .q_tag    (rd_tag),
    .q_vaddr  (exc_vaddr),
    .q_mcause (exc_mem_cause)
  );

  assert_pass_gates_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mem_fault && verdict == 2'd0
    |=> rd_we && rd_tag == ($past(ld_tag) & $past(auth_lc_perm)) && rd_cap == $past(ld_cap));
  assert_strip_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mem_fault && verdict == 2'd1 |=> rd_we && !rd_tag && retire_ok);
  assert_trap_tagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mem_fault && verdict[1] && ld_tag
    |=> !rd_we && exc_code == 2'd2 && exc_vaddr == $past(vaddr));
  assert_trap_untagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mem_fault && verdict[1] && !ld_tag
    |=> rd_we && !rd_tag && retire_ok && rd_cap == $past(ld_cap));
  assert_memfault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mem_fault
    |=> retire_fail && exc_code == 2'd1 && !rd_we && !resv_set && exc_mem_cause == $past(mem_cause));
  assert_resv_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lr_variant && !mem_fault && !(verdict[1] && ld_tag) |=> resv_set);

endmodule

// File: tb/cap_load_filter_tb.sv
module cap_load_filter_tb;

  localparam int unsigned CAP_W   = 64;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CAUSE_W = 5;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [1:0]         verdict = '0;
  logic [CAP_W-1:0]   ld_cap = '0;
  logic               ld_tag = 1'b0;
  logic               auth_lc_perm = 1'b0;
  logic               mem_fault = 1'b0;
  logic [CAUSE_W-1:0] mem_cause = '0;
  logic               lr_variant = 1'b0;
  logic [ADDR_W-1:0]  vaddr = '0;
  logic               out_valid, rd_tag, rd_we, retire_ok, retire_fail, resv_set;
  logic [CAP_W-1:0]   rd_cap;
  logic [1:0]         exc_code;
  logic [CAUSE_W-1:0] exc_mem_cause;
  logic [ADDR_W-1:0]  exc_vaddr;

  cap_load_filter #(.CAP_W(CAP_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .verdict(verdict),
    .ld_cap(ld_cap), .ld_tag(ld_tag), .auth_lc_perm(auth_lc_perm),
    .mem_fault(mem_fault), .mem_cause(mem_cause), .lr_variant(lr_variant),
    .vaddr(vaddr), .out_valid(out_valid), .rd_cap(rd_cap), .rd_tag(rd_tag),
    .rd_we(rd_we), .retire_ok(retire_ok), .retire_fail(retire_fail),
    .exc_code(exc_code), .exc_mem_cause(exc_mem_cause), .exc_vaddr(exc_vaddr),
    .resv_set(resv_set)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic               we, ok, fail, tag, resv;
    logic [1:0]         code;
    logic [CAP_W-1:0]   cap;
    logic [ADDR_W-1:0]  va;
    logic [CAUSE_W-1:0] mc;
    int                 due;
    string              req;
  } exp_t;

  exp_t             sb[$];
  int               checks = 0;
  int               errors = 0;
  int               cyc = 0;
  logic [CAP_W-1:0] mdl_cap = '0;
  logic             mdl_tag = 1'b0;
  bit               done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit good, input string req, input string what,
                     input logic [CAP_W-1:0] act, input logic [CAP_W-1:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] v, input logic [CAP_W-1:0] c, input logic t,
                       input logic p, input logic mf, input logic [CAUSE_W-1:0] mc,
                       input logic lr, input logic [ADDR_W-1:0] va, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; verdict = v; ld_cap = c; ld_tag = t; auth_lc_perm = p;
    mem_fault = mf; mem_cause = mc; lr_variant = lr; vaddr = va;
    e.req = req; e.due = cyc + 1; e.va = va; e.mc = mc;
    if (mf) begin
      e.we = 0; e.ok = 0; e.fail = 1; e.code = 2'd1; e.resv = 0;
    end else if (v[1] && t) begin
      e.we = 0; e.ok = 0; e.fail = 1; e.code = 2'd2; e.resv = 0;
    end else begin
      e.we = 1; e.ok = 1; e.fail = 0; e.code = 2'd0; e.resv = lr;
      mdl_cap = c;
      mdl_tag = (v == 2'd0) ? (t & p) : (v == 2'd1) ? 1'b0 : t;
    end
    e.cap = mdl_cap; e.tag = mdl_tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: samples on falling edges, away from the capturing edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R2", "pulse with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.due == cyc, "R2", {e.req, " latency"}, cyc, e.due);
          chk(rd_we == e.we, e.req, "rd_we", rd_we, e.we);
          chk(retire_ok == e.ok && retire_fail == e.fail, e.req, "retire ok/fail",
              {retire_ok, retire_fail}, {e.ok, e.fail});
          chk(exc_code == e.code, e.req, "exc_code", exc_code, e.code);
          chk(resv_set == e.resv, e.req, "resv_set (R8)", resv_set, e.resv);
          chk(rd_cap == e.cap && rd_tag == e.tag, e.req, "rd_cap/rd_tag",
              {rd_tag, rd_cap[CAP_W-2:0]}, {e.tag, e.cap[CAP_W-2:0]});
          if (e.fail) chk(exc_vaddr == e.va, e.req, "exc_vaddr", exc_vaddr, e.va);
          if (e.code == 2'd1) chk(exc_mem_cause == e.mc, e.req, "exc_mem_cause (R7)",
                                  exc_mem_cause, e.mc);
        end
      end else if (sb.size() != 0 && sb[0].due <= cyc) begin
        chk(0, "R2", "missing pulse", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(!out_valid && !rd_we && !retire_ok && !retire_fail && !resv_set && exc_code == 0,
        "R1", "outputs in reset", {out_valid, rd_we, retire_ok, retire_fail, resv_set}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(!out_valid && exc_code == 0 && !resv_set, "R1", "idle after reset",
        {out_valid, exc_code, resv_set}, 0);

    // R3 pass verdict, tag gated by permission
    issue(2'd0, 64'hA5A5_0001_DEAD_BEEF, 1, 1, 0, 5'd0, 0, 32'h1000, "R3");
    issue(2'd0, 64'h0000_1111_2222_3333, 1, 0, 0, 5'd0, 0, 32'h1008, "R3");
    issue(2'd0, 64'h7777_0000_0000_0042, 0, 1, 0, 5'd0, 1, 32'h1010, "R3");
    idle(1);
    // R4 strip verdict
    issue(2'd1, 64'h8000_0000_0000_0001, 1, 1, 0, 5'd0, 1, 32'h2000, "R4");
    issue(2'd1, 64'h0123_4567_89AB_CDEF, 0, 1, 0, 5'd0, 0, 32'h2008, "R4");
    idle(2);
    // R5 trap with tag: no write, value held
    issue(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 5'd0, 1, 32'h3000, "R5");
    issue(2'd2, 64'h1234_0000_0000_5678, 1, 0, 0, 5'd0, 0, 32'h3010, "R5");
    // R6 trap with tag clear: written unchanged
    issue(2'd2, 64'h0BAD_F00D_0000_0007, 0, 1, 0, 5'd0, 1, 32'h3020, "R6");
    idle(1);
    // R9 reserved code behaves as trap
    issue(2'd3, 64'h5555_AAAA_5555_AAAA, 1, 1, 0, 5'd0, 1, 32'h4000, "R9");
    issue(2'd3, 64'h0000_0000_CAFE_0001, 0, 0, 0, 5'd0, 1, 32'h4008, "R9");
    // R7 memory fault overrides each verdict
    issue(2'd0, 64'h1111_1111_1111_1111, 1, 1, 1, 5'd13, 1, 32'h5000, "R7");
    issue(2'd1, 64'h2222_2222_2222_2222, 0, 1, 1, 5'd5,  1, 32'h5008, "R7");
    issue(2'd2, 64'h3333_3333_3333_3333, 0, 1, 1, 5'd31, 0, 32'h5010, "R7");
    idle(3);
    // R8 reservation across paths
    issue(2'd0, 64'h0000_0000_0000_00A8, 1, 1, 0, 5'd0, 1, 32'h6000, "R8");
    issue(2'd2, 64'h0000_0000_0000_00B8, 1, 1, 0, 5'd0, 1, 32'h6008, "R8");
    issue(2'd1, 64'h0000_0000_0000_00C8, 1, 0, 0, 5'd0, 0, 32'h6010, "R8");
    // R10 back-to-back mixed outcomes
    for (int i = 0; i < 16; i++)
      issue(i[1:0], {32'h9000_0000 + i, 32'h0000_1000 * i}, i[2], i[3], (i % 5) == 4,
            5'(i), i[0], 32'h7000 + 32'(i * 8), "R10");
    idle(4);
    chk(sb.size() == 0, "R2", "all expectations consumed", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule